// File: doc/BRIEF.md
# Serial Link Timing and Status Engine

This block is a byte-wide serial link helper placed behind a processor I/O port. A control write selects how far the system clock is divided before it reaches the link logic and how many of those divided ticks each bit lasts. A transmit write hands the engine one byte, which it shifts out on a single wire. A receiver watches the incoming wire, rebuilds bytes and keeps the last one for the processor to collect. The same frame format is used in both directions: an idle-high line, one low start bit, eight data bits sent least significant bit first, and one high stop bit.

The processor can read an 8-bit status word at any time. Its low three bits record why an interrupt was raised: a byte arrived, the transmitter became free, or a receive error occurred. These cause bits clear when the status word is read. The upper five bits show live conditions: the transmitter or the receiver is busy, a received byte is waiting, the transmitter can accept a byte, or an error has occurred. The interrupt line is high while any cause bit is set. The all-ones divider code freezes the engine completely.

Top module: `link_assist`

## Requirements
- R1: Control bits 7..5 hold a code n from 0 to 6. The link logic then advances once every 2^n system clocks, so each bit on `line_out` lasts (gap+1)·2^n clocks and the start bit of a frame is low for exactly that many clocks.
- R2: When the code is 7 (111b), neither the transmitter nor the receiver advances. `line_out` does not change, a low level on `line_in` starts no reception, and a byte accepted while frozen is sent once a code from 0 to 6 is written.
- R3: Control bits 4..0 hold a gap value g. Each bit lasts g+1 divided ticks. The receiver takes its k-th sample k·(g+1) ticks after it detects the start bit.
- R4: A frame is one low start bit, eight data bits least significant bit first, and one high stop bit, with the line high between frames. A frame that is looped from `line_out` back to `line_in` produces the byte that was sent on `rx_rdata`.
- R5: The status bits are, from bit 7 down to bit 0: transmitter busy, error, ready to send, received byte waiting, receiver busy, error cause, transmit-free cause, byte-received cause. Bit 7 is 1 from the clock after an accepted transmit write until the stop bit has finished. Bit 3 is 1 while a frame is being received.
- R6: Bit 0 sets when a frame completes with a high stop bit. Bit 1 sets when a transmission finishes. Bit 2 sets on a receive error. `irq` is 1 exactly when at least one of bits 2..0 is 1.
- R7: A status read (`stat_re` high for one clock) clears bits 2..0 from the next clock onward, unless a new cause arrives in that same clock. Bits 7..3 are not affected by the read.
- R8: A transmit write while bit 5 is 1 is accepted: bit 5 reads 0 and bit 7 reads 1 from the next clock. A transmit write while bit 5 is 0 is ignored. Reading `rx_rdata` with `rx_re` clears bit 4 from the next clock.
- R9: A receive error is either a low stop bit or 255 consecutive divided ticks with no change on the line during a frame. The partial byte is discarded, so bit 4 stays 0 and `rx_rdata` keeps its old value. Bits 6 and 2 set together. Bit 6 stays set through status reads and clears when the next start bit is detected.
- R10: After reset the divider code and the gap are 0, the status word reads 0x20 (only ready to send is set), `irq` is 0 and `line_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, shared with the processor |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control value: [7:5] divider code, [4:0] gap |
| stat_re | input | 1 | Status read strobe; clears the cause bits |
| stat_rdata | output | 8 | Status word |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Byte to send |
| rx_re | input | 1 | Receive byte read strobe |
| rx_rdata | output | 8 | Last byte received correctly |
| line_in | input | 1 | Serial line input, asynchronous |
| line_out | output | 1 | Serial line output, idle high |
| irq | output | 1 | Interrupt request, high while any cause bit is set |

## Verification
Strobe results are due one clock after the strobe. After a transmit, status, or receive-data strobe, the bench samples the status word at the next falling edge, which is the first point after the register update. The start-bit width is counted in whole clocks between falling edges and compared with (g+1)·2^n. The end of a frame depends on the phase of the divider and on the two-flop input synchronizer, so the bench polls the live status bits until that frame is complete. Freeze and stall behaviour is checked at fixed points: one point lies well inside the 255-tick window and the other lies between that window and the time at which the stop bit would be sampled.

// File: rtl/link_pkg.sv
package link_pkg;

  // Bit positions in the status word read by the processor
  localparam int ST_IRQ_RX  = 0;
  localparam int ST_IRQ_TX  = 1;
  localparam int ST_IRQ_ERR = 2;
  localparam int ST_RX_BUSY = 3;
  localparam int ST_RX_FULL = 4;
  localparam int ST_TX_RDY  = 5;
  localparam int ST_ERR     = 6;
  localparam int ST_TX_BUSY = 7;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

endpackage

// File: rtl/link_prescaler.sv
module link_prescaler #(
  parameter int DIV_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             halt;

  assign halt = (code == {DIV_W{1'b1}});

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(code));
    end
  end

  assign tick = !halt && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)    cnt_d = '0;
    else if (!halt) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/link_tx.sv
module link_tx import link_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [GAP_W-1:0]  gap,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              line,
  output logic              busy,
  output logic              done
);

  localparam int LAST  = DATA_W + 1;
  localparam int BIT_W = $clog2(DATA_W + 2);

  tx_state_e         st_q, st_d;
  logic [GAP_W-1:0]  tcnt_q, tcnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic              line_q, line_d;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bit_d  = bit_q;
    shr_d  = shr_q;
    line_d = line_q;
    done   = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (load) begin
          shr_d = din;
          st_d  = TX_ARM;
        end
      end
      TX_ARM: begin
        if (tick) begin
          line_d = 1'b0;
          tcnt_d = '0;
          bit_d  = '0;
          st_d   = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        if (tick) begin
          if (tcnt_q == gap) begin
            tcnt_d = '0;
            if (bit_q == BIT_W'(LAST)) begin
              st_d = TX_IDLE;
              done = 1'b1;
            end else begin
              bit_d = bit_q + BIT_W'(1);
              if (bit_q == BIT_W'(DATA_W)) begin
                line_d = 1'b1;
              end else begin
                line_d = shr_q[0];
                shr_d  = shr_q >> 1;
              end
            end
          end else begin
            tcnt_d = tcnt_q + GAP_W'(1);
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      tcnt_q <= '0;
      bit_q  <= '0;
      shr_q  <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bit_q  <= bit_d;
      shr_q  <= shr_d;
      line_q <= line_d;
    end
  end

  assign line = line_q;
  assign busy = (st_q != TX_IDLE);

endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int DATA_W      = 8,
  parameter int GAP_W       = 5,
  parameter int STALL_TICKS = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [GAP_W-1:0]  gap,
  input  logic              line_in,
  output logic              busy,
  output logic              start,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] data
);

  localparam int BIT_W   = $clog2(DATA_W + 2);
  localparam int STALL_W = $clog2(STALL_TICKS + 1);

  logic              sync1_q, ln_q;
  logic              last_q, last_d;
  logic              busy_q, busy_d;
  logic [GAP_W-1:0]  tcnt_q, tcnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [STALL_W-1:0] stall_q, stall_d;
  logic [DATA_W-1:0] shr_q, shr_d, data_q, data_d;
  logic              chg;

  assign chg   = (ln_q != last_q);
  assign start = tick && !busy_q && !ln_q && last_q;

  always_comb begin
    last_d  = tick ? ln_q : last_q;
    busy_d  = busy_q;
    tcnt_d  = tcnt_q;
    bit_d   = bit_q;
    stall_d = stall_q;
    shr_d   = shr_q;
    data_d  = data_q;
    done    = 1'b0;
    err     = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      tcnt_d  = '0;
      bit_d   = '0;
      stall_d = '0;
    end else if (tick && busy_q) begin
      stall_d = chg ? '0 : stall_q + STALL_W'(1);
      if (!chg && (stall_q == STALL_W'(STALL_TICKS - 1))) begin
        err    = 1'b1;
        busy_d = 1'b0;
      end else if (tcnt_q == gap) begin
        tcnt_d = '0;
        bit_d  = bit_q + BIT_W'(1);
        if (bit_q == BIT_W'(DATA_W)) begin
          busy_d = 1'b0;
          if (ln_q) begin
            done   = 1'b1;
            data_d = shr_q;
          end else begin
            err = 1'b1;
          end
        end else begin
          shr_d = {ln_q, shr_q[DATA_W-1:1]};
        end
      end else begin
        tcnt_d = tcnt_q + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      ln_q    <= 1'b1;
      last_q  <= 1'b1;
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      bit_q   <= '0;
      stall_q <= '0;
      shr_q   <= '0;
      data_q  <= '0;
    end else begin
      sync1_q <= line_in;
      ln_q    <= sync1_q;
      last_q  <= last_d;
      busy_q  <= busy_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      stall_q <= stall_d;
      shr_q   <= shr_d;
      data_q  <= data_d;
    end
  end

  assign busy = busy_q;
  assign data = data_q;

endmodule

// File: rtl/link_flags.sv
module link_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rx_err,
  input  logic rx_start,
  input  logic tx_done,
  input  logic stat_re,
  input  logic rx_re,
  output logic irq_rx,
  output logic irq_tx,
  output logic irq_err,
  output logic full,
  output logic err
);

  logic irq_rx_d, irq_tx_d, irq_err_d, full_d, err_d;

  always_comb begin
    irq_rx_d  = rx_done | (irq_rx  & ~stat_re);
    irq_tx_d  = tx_done | (irq_tx  & ~stat_re);
    irq_err_d = rx_err  | (irq_err & ~stat_re);
    full_d    = rx_done | (full    & ~rx_re);
    err_d     = rx_err  | (err     & ~rx_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx  <= 1'b0;
      irq_tx  <= 1'b0;
      irq_err <= 1'b0;
      full    <= 1'b0;
      err     <= 1'b0;
    end else begin
      irq_rx  <= irq_rx_d;
      irq_tx  <= irq_tx_d;
      irq_err <= irq_err_d;
      full    <= full_d;
      err     <= err_d;
    end
  end

endmodule

// File: rtl/link_assist.sv
module link_assist import link_pkg::*; #(
  parameter int DIV_W       = 3,
  parameter int GAP_W       = 5,
  parameter int DATA_W      = 8,
  parameter int STALL_TICKS = 255
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_we,
  input  logic [DIV_W+GAP_W-1:0] ctrl_wdata,
  input  logic                   stat_re,
  output logic [7:0]             stat_rdata,
  input  logic                   tx_we,
  input  logic [DATA_W-1:0]      tx_wdata,
  input  logic                   rx_re,
  output logic [DATA_W-1:0]      rx_rdata,
  input  logic                   line_in,
  output logic                   line_out,
  output logic                   irq
);

  localparam int CNT_W = (1 << DIV_W) - 2;

  logic [1:0]       rs_q;
  logic             rst_s;
  logic [DIV_W-1:0] code_q, code_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             tick, tx_busy, tx_done;
  logic             rx_busy, rx_start, rx_done, rx_err;
  logic             irq_rx, irq_tx, irq_err, rx_full, err_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  always_comb begin
    code_d = code_q;
    gap_d  = gap_q;
    if (ctrl_we) begin
      code_d = ctrl_wdata[DIV_W+GAP_W-1:GAP_W];
      gap_d  = ctrl_wdata[GAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      code_q <= '0;
      gap_q  <= '0;
    end else begin
      code_q <= code_d;
      gap_q  <= gap_d;
    end
  end

  link_prescaler #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .restart(ctrl_we), .code(code_q), .tick(tick)
  );

  link_tx #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_tx (
    .clk(clk), .rst_n(rst_s), .tick(tick), .gap(gap_q), .load(tx_we),
    .din(tx_wdata), .line(line_out), .busy(tx_busy), .done(tx_done)
  );

  link_rx #(.DATA_W(DATA_W), .GAP_W(GAP_W), .STALL_TICKS(STALL_TICKS)) u_rx (
    .clk(clk), .rst_n(rst_s), .tick(tick), .gap(gap_q), .line_in(line_in),
    .busy(rx_busy), .start(rx_start), .done(rx_done), .err(rx_err),
    .data(rx_rdata)
  );

  link_flags u_flags (
    .clk(clk), .rst_n(rst_s), .rx_done(rx_done), .rx_err(rx_err),
    .rx_start(rx_start), .tx_done(tx_done), .stat_re(stat_re), .rx_re(rx_re),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err), .full(rx_full),
    .err(err_flag)
  );

  always_comb begin
    stat_rdata             = '0;
    stat_rdata[ST_IRQ_RX]  = irq_rx;
    stat_rdata[ST_IRQ_TX]  = irq_tx;
    stat_rdata[ST_IRQ_ERR] = irq_err;
    stat_rdata[ST_RX_BUSY] = rx_busy;
    stat_rdata[ST_RX_FULL] = rx_full;
    stat_rdata[ST_TX_RDY]  = !tx_busy;
    stat_rdata[ST_ERR]     = err_flag;
    stat_rdata[ST_TX_BUSY] = tx_busy;
  end

  assign irq = irq_rx | irq_tx | irq_err;

endmodule

// File: rtl/link_assist_chk.sv
module link_assist_chk #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_we,
  input logic             stat_re,
  input logic             rx_re,
  input logic [DIV_W-1:0] code_q,
  input logic [7:0]       stat,
  input logic             line_out,
  input logic             rx_done
);

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && stat[5]) |=> (!stat[5] && stat[7])); // R8

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q == {DIV_W{1'b1}}) && $past(code_q == {DIV_W{1'b1}})) |-> $stable(line_out)); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[7] |-> line_out); // R4

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && !rx_done) |=> !stat[0]); // R7

  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_re && !rx_done) |=> !stat[4]); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[6]) |-> stat[2]); // R9

  AST_FULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> $past(rx_done)); // R6

endmodule

bind link_assist link_assist_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .tx_we(tx_we), .stat_re(stat_re), .rx_re(rx_re),
  .code_q(code_q), .stat(stat_rdata), .line_out(line_out), .rx_done(rx_done)
);

// File: tb/link_assist_test.sv
`timescale 1ns/1ps
module link_assist_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we, stat_re, tx_we, rx_re;
  logic [7:0] ctrl_wdata, tx_wdata;
  logic [7:0] stat_rdata, rx_rdata;
  logic       line_in, line_out, irq;
  logic       loop_en, drv_line;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign line_in = loop_en ? line_out : drv_line;

  link_assist uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_re(stat_re), .stat_rdata(stat_rdata), .tx_we(tx_we),
    .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
    .line_in(line_in), .line_out(line_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input int code, input int gap);
    ctrl_wdata = 8'((code << 5) | gap);
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic read_status_clear(input string req);
    stat_re = 1'b1;
    @(negedge clk);
    stat_re = 1'b0;
    check({req, " cause bits cleared by read"}, stat_rdata[2:0], 3'b000);
    check({req, " irq low after read"}, irq, 1'b0);
  endtask

  task automatic wait_frame_done;
    for (int k = 0; k < 40000; k++) begin
      if (stat_rdata[4] && stat_rdata[5]) break;
      @(negedge clk);
    end
  endtask

  task automatic send_loop(input int code, input int gap, input logic [7:0] b);
    int  low_cnt;
    bit  seen_rx;
    write_ctrl(code, gap);
    tx_wdata = b;
    tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
    check("R8 ready drops after accepted write", stat_rdata[5], 1'b0);
    check("R5 tx busy after accepted write", stat_rdata[7], 1'b1);
    for (int k = 0; k < 20000; k++) begin
      if (!line_out) break;
      @(negedge clk);
    end
    low_cnt = 0;
    seen_rx = 1'b0;
    while (!line_out && low_cnt < 20000) begin
      low_cnt++;
      if (stat_rdata[3]) seen_rx = 1'b1;
      @(negedge clk);
    end
    check("R1 R3 start bit width", low_cnt, (gap + 1) << code);
    for (int k = 0; k < 40000; k++) begin
      if (stat_rdata[4] && stat_rdata[5]) break;
      if (stat_rdata[3]) seen_rx = 1'b1;
      @(negedge clk);
    end
    check("R5 rx busy seen during frame", seen_rx, 1'b1);
    check("R6 byte-received cause", stat_rdata[0], 1'b1);
    check("R6 transmit-free cause", stat_rdata[1], 1'b1);
    check("R6 irq high", irq, 1'b1);
    check("R9 error bit clear after good frame", stat_rdata[6], 1'b0);
    rx_re = 1'b1;
    #1;
    check("R4 looped byte", rx_rdata, b);
    @(negedge clk);
    rx_re = 1'b0;
    check("R8 byte waiting cleared by data read", stat_rdata[4], 1'b0);
    read_status_clear("R7");
    check("R7 ready unaffected by read", stat_rdata[5], 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int  idx;
    bit  stayed;
    rst_n = 1'b0;
    ctrl_we = 1'b0; stat_re = 1'b0; tx_we = 1'b0; rx_re = 1'b0;
    ctrl_wdata = '0; tx_wdata = '0;
    loop_en = 1'b1; drv_line = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R10 reset status", stat_rdata, 8'h20);
    check("R10 reset irq", irq, 1'b0);
    check("R10 reset line", line_out, 1'b1);
    // Reset code 0 / gap 0: start bit lasts one clock
    begin
      int lc;
      tx_wdata = 8'h81; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
      for (int k = 0; k < 100; k++) begin if (!line_out) break; @(negedge clk); end
      lc = 0;
      while (!line_out && lc < 100) begin lc++; @(negedge clk); end
      check("R10 default divider and gap", lc, 1);
      wait_frame_done();
      rx_re = 1'b1; @(negedge clk); rx_re = 1'b0;
      stat_re = 1'b1; @(negedge clk); stat_re = 1'b0;
    end

    // Sweep of all running divider codes and several gaps
    idx = 0;
    for (int c = 0; c < 7; c++) begin
      for (int gi = 0; gi < 3; gi++) begin
        int g;
        g = (gi == 0) ? 0 : ((gi == 1) ? 1 : 5);
        send_loop(c, g, 8'((idx * 37 + 17) | 1));
        idx++;
      end
    end
    send_loop(2, 3, 8'hFF);
    send_loop(0, 7, 8'h01);

    // R8 write while busy is ignored
    write_ctrl(1, 1);
    tx_wdata = 8'hC3; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
    repeat (6) @(negedge clk);
    tx_wdata = 8'h3C; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
    wait_frame_done();
    check("R8 first byte kept when busy write ignored", rx_rdata, 8'hC3);
    stayed = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (!line_out || stat_rdata[7]) stayed = 1'b0;
      @(negedge clk);
    end
    check("R8 no second frame after ignored write", stayed, 1'b1);
    rx_re = 1'b1; @(negedge clk); rx_re = 1'b0;
    read_status_clear("R7");

    // R2 freeze
    write_ctrl(7, 0);
    tx_wdata = 8'h55; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
    check("R2 byte accepted while frozen", stat_rdata[7], 1'b1);
    stayed = 1'b1;
    for (int k = 0; k < 300; k++) begin
      if (!line_out) stayed = 1'b0;
      @(negedge clk);
    end
    check("R2 line unchanged while frozen", stayed, 1'b1);
    check("R2 transmitter still pending", stat_rdata[7], 1'b1);
    loop_en = 1'b0; drv_line = 1'b0;
    repeat (100) @(negedge clk);
    check("R2 no reception while frozen", stat_rdata[3], 1'b0);
    drv_line = 1'b1;
    repeat (5) @(negedge clk);
    loop_en = 1'b1;
    write_ctrl(0, 2);
    wait_frame_done();
    check("R2 pending byte sent after resume", rx_rdata, 8'h55);
    check("R2 transmit-free cause after resume", stat_rdata[1], 1'b1);
    rx_re = 1'b1; @(negedge clk); rx_re = 1'b0;
    read_status_clear("R7");

    // R9 low stop bit
    write_ctrl(0, 0);
    loop_en = 1'b0; drv_line = 1'b0;
    repeat (40) @(negedge clk);
    check("R9 error bit on low stop", stat_rdata[6], 1'b1);
    check("R9 error cause on low stop", stat_rdata[2], 1'b1);
    check("R9 irq on error", irq, 1'b1);
    check("R9 no byte waiting after error", stat_rdata[4], 1'b0);
    check("R9 data kept after error", rx_rdata, 8'h55);
    check("R9 receiver idle after error", stat_rdata[3], 1'b0);
    read_status_clear("R7");
    check("R9 error bit survives status read", stat_rdata[6], 1'b1);
    drv_line = 1'b1;
    repeat (10) @(negedge clk);

    // R9 stall of 255 ticks, gap 31 puts the stop sample later
    write_ctrl(0, 31);
    drv_line = 1'b0;
    repeat (240) @(negedge clk);
    check("R9 error bit cleared by new start", stat_rdata[6], 1'b0);
    check("R9 still receiving before stall limit", stat_rdata[3], 1'b1);
    repeat (35) @(negedge clk);
    check("R9 stall error raised", stat_rdata[6], 1'b1);
    check("R9 stall ends reception", stat_rdata[3], 1'b0);
    check("R9 stall discards byte", stat_rdata[4], 1'b0);
    read_status_clear("R7");
    drv_line = 1'b1;
    repeat (10) @(negedge clk);
    loop_en = 1'b1;

    send_loop(0, 0, 8'h99);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule